// File: doc/BRIEF.md
# Stack Machine Evaluation Core

This block is a small zero-address processor that evaluates arithmetic expressions on an operand stack held in hardware. Its instructions carry no register names. Each one takes its operands from fixed stack positions. A memory reference moves a word between the data memory and the top of the stack. A duplicate copies the top entry. An arithmetic operation consumes the two topmost entries and leaves the result in their place. Only the top two entries can be reached. A deeper value becomes visible only after everything above it has been popped.

The core holds eight 32-bit stack entries and steps a program counter through an instruction memory one instruction per cycle. It does this while `run` is high and until it meets a halt instruction. Both memories are loaded through a preload port while `run` is low. Outside logic watches the top-of-stack value, the stack depth, two sticky error flags for overflow and underflow, and a halted flag.

Each instruction is 16 bits wide. Bits 15:12 hold the opcode and bits 11:0 hold the address field. The data memory is indexed by the low bits of that field. The opcode values are:

- LOAD = 1
- STORE = 2
- ADD = 3
- SUB = 4
- MUL = 5
- DUP = 6
- HALT = 15

Top module: `stack_eval_core`

## Requirements
- R1: After reset the depth is 0, the top-of-stack output is 0, overflow, underflow and halted are all 0, and execution begins at instruction address 0.
- R2: LOAD (opcode 1) reads the data word at the address field and pushes it, so the depth grows by one and the top-of-stack output shows that word.
- R3: STORE (opcode 2) pops the top entry and writes it to the data word at the address field; a later LOAD of that address returns it.
- R4: ADD (opcode 3) and MUL (opcode 5) pop two entries and push their sum or product modulo 2^32, so the depth drops by one.
- R5: SUB (opcode 4) pushes the second-from-top entry minus the top entry, modulo 2^32.
- R6: DUP (opcode 6) pushes a copy of the top entry and leaves the original in place.
- R7: Exactly one instruction executes on each rising clock edge while `run` is high, taken from sequential addresses; while `run` is low the stack and depth stay unchanged.
- R8: A push onto a stack holding 8 entries is suppressed: the depth stays 8 and the top entry is unchanged. The overflow flag is set and stays set until reset.
- R9: A pop from an empty stack yields zero and sets the underflow flag, which stays set until reset. A STORE on an empty stack writes zero. ADD or SUB with one entry uses zero for the missing second operand.
- R10: HALT (opcode 15) sets the halted flag; from then on no instruction executes and no output changes until reset.
- R11: Evaluating (B+C)*(D+E) with LOADs and arithmetic and then a STORE leaves the depth equal to its value before the sequence began.
- R12: Any opcode without an assigned meaning leaves the stack, the depth and the flags unchanged, and the program counter still advances.
- R13: The depth output never exceeds 8, and the top-of-stack output is 0 whenever the depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Execute one instruction per cycle while high |
| plWrInstr | input | 1 | Preload strobe: write plData[15:0] to instruction memory at plAddr |
| plWrData | input | 1 | Preload strobe: write plData to data memory at plAddr |
| plAddr | input | 12 | Preload address (low bits used) |
| plData | input | 32 | Preload write value |
| tos | output | 32 | Value of the top stack entry, 0 when empty |
| depth | output | 4 | Number of entries on the stack, 0 to 8 |
| overflow | output | 1 | Sticky flag: a push met a full stack |
| underflow | output | 1 | Sticky flag: a pop met an empty stack |
| halted | output | 1 | A HALT instruction has executed |

## Verification
A wrong stack pointer or a wrong entry shows up on `tos` and `depth` after the very next executed instruction. Both are registered, so the bench steps the core a chosen number of cycles and compares them exactly. Faults in storage below the top two entries stay hidden until enough pops expose them. For that reason the expression sweeps keep a base entry under the expression and read it back afterwards. A wrong write into data memory only appears once a later LOAD of the same address brings the stored value back onto the stack.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_MUL   = 4'd5;
  localparam logic [3:0] OP_DUP   = 4'd6;
  localparam logic [3:0] OP_HALT  = 4'd15;

  typedef enum logic [1:0] {
    SRC_MEM = 2'd0,
    SRC_ALU = 2'd1,
    SRC_TOP = 2'd2
  } pushSrc_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluOp_e;

  // Strobes from control to datapath for one executed instruction.
  typedef struct packed {
    logic     pushEn;   // write one entry after the pops
    logic [1:0] popCnt; // entries actually removed (never more than held)
    pushSrc_e pushSrc;
    aluOp_e   aluOp;
    logic     memWr;    // write popped top (or zero) to data memory
    logic     pcAdv;
    logic     setHalt;
    logic     setOvf;
    logic     setUdf;
  } ctrl_t;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_core_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic [3:0]         opcode,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               run,
  input  logic               halted,
  output ctrl_t              strb
);

  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);
  localparam logic [DEPTH_W-1:0] TWO  = DEPTH_W'(2);

  logic isEmpty, isFull, hasTwo;

  assign isEmpty = (depth == '0);
  assign isFull  = (depth == FULL);
  assign hasTwo  = (depth >= TWO);

  always_comb begin
    strb = '0;
    strb.pushSrc = SRC_MEM;
    strb.aluOp   = ALU_ADD;
    if (run && !halted) begin
      strb.pcAdv = 1'b1;
      unique case (opcode)
        OP_LOAD: begin
          strb.pushSrc = SRC_MEM;
          if (isFull) strb.setOvf = 1'b1;
          else        strb.pushEn = 1'b1;
        end
        OP_STORE: begin
          strb.memWr = 1'b1;
          if (isEmpty) strb.setUdf = 1'b1;
          else         strb.popCnt = 2'd1;
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          strb.pushSrc = SRC_ALU;
          strb.aluOp   = (opcode == OP_ADD) ? ALU_ADD :
                         (opcode == OP_SUB) ? ALU_SUB : ALU_MUL;
          strb.pushEn  = 1'b1;
          if (hasTwo) begin
            strb.popCnt = 2'd2;
          end else begin
            strb.setUdf = 1'b1;
            strb.popCnt = isEmpty ? 2'd0 : 2'd1;
          end
        end
        OP_DUP: begin
          strb.pushSrc = SRC_TOP;
          if (isFull) begin
            strb.setOvf = 1'b1;
          end else begin
            strb.pushEn = 1'b1;
            if (isEmpty) strb.setUdf = 1'b1;
          end
        end
        OP_HALT: begin
          strb.pcAdv   = 1'b0;
          strb.setHalt = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_datapath.sv
module stack_datapath
  import stack_core_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 12,
  parameter int IMEM_AW = 5,
  parameter int DMEM_AW = 5,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              strb,
  input  logic               plWrInstr,
  input  logic               plWrData,
  input  logic [ADDR_W-1:0]  plAddr,
  input  logic [DATA_W-1:0]  plData,
  output logic [3:0]         opcode,
  output logic [DEPTH_W-1:0] depth,
  output logic [DATA_W-1:0]  tos,
  output logic               overflow,
  output logic               underflow,
  output logic               halted
);

  localparam int INSTR_W = ADDR_W + 4;
  localparam int IMEM_N  = 1 << IMEM_AW;
  localparam int DMEM_N  = 1 << DMEM_AW;
  localparam int IDX_W   = $clog2(DEPTH);

  logic [IMEM_AW-1:0] pc;
  logic [INSTR_W-1:0] imem [IMEM_N];
  logic [DATA_W-1:0]  dmem [DMEM_N];
  logic [DATA_W-1:0]  stk  [DEPTH];

  logic [INSTR_W-1:0] instr;
  logic [ADDR_W-1:0]  addrField;
  logic [DMEM_AW-1:0] memIdx;
  logic [DATA_W-1:0]  memRd, topVal, nextVal, aluRes, pushVal;
  logic [DEPTH_W-1:0] afterPop, newDepth;
  logic [IDX_W-1:0]   wrIdx;

  assign instr     = imem[pc];
  assign opcode    = instr[INSTR_W-1 -: 4];
  assign addrField = instr[ADDR_W-1:0];
  assign memIdx    = addrField[DMEM_AW-1:0];
  assign memRd     = dmem[memIdx];

  // Only the two topmost entries are readable.
  assign topVal  = (depth != '0) ? stk[IDX_W'(depth - DEPTH_W'(1))] : '0;
  assign nextVal = (depth >= DEPTH_W'(2)) ? stk[IDX_W'(depth - DEPTH_W'(2))] : '0;
  assign tos     = topVal;

  always_comb begin
    unique case (strb.aluOp)
      ALU_SUB: aluRes = nextVal - topVal;
      ALU_MUL: aluRes = nextVal * topVal;
      default: aluRes = nextVal + topVal;
    endcase
  end

  always_comb begin
    unique case (strb.pushSrc)
      SRC_ALU: pushVal = aluRes;
      SRC_TOP: pushVal = topVal;
      default: pushVal = memRd;
    endcase
  end

  assign afterPop = depth - DEPTH_W'(strb.popCnt);
  assign wrIdx    = IDX_W'(afterPop);
  assign newDepth = afterPop + DEPTH_W'(strb.pushEn);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth     <= '0;
      pc        <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      halted    <= 1'b0;
    end else begin
      depth     <= newDepth;
      pc        <= pc + IMEM_AW'(strb.pcAdv);
      overflow  <= overflow | strb.setOvf;
      underflow <= underflow | strb.setUdf;
      halted    <= halted | strb.setHalt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) stk[i] <= '0;
      else if (strb.pushEn && (wrIdx == IDX_W'(i))) stk[i] <= pushVal;
    end
  end

  always_ff @(posedge clk) begin
    if (plWrInstr) imem[plAddr[IMEM_AW-1:0]] <= plData[INSTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (plWrData)        dmem[plAddr[DMEM_AW-1:0]] <= plData;
    else if (strb.memWr) dmem[memIdx] <= topVal;
  end

endmodule

// File: rtl/stack_eval_core.sv
module stack_eval_core
  import stack_core_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 12,
  parameter int IMEM_AW = 5,
  parameter int DMEM_AW = 5,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               plWrInstr,
  input  logic               plWrData,
  input  logic [ADDR_W-1:0]  plAddr,
  input  logic [DATA_W-1:0]  plData,
  output logic [DATA_W-1:0]  tos,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflow,
  output logic               underflow,
  output logic               halted
);

  ctrl_t      strb;
  logic [3:0] opcode;

  stack_ctrl #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_ctrl (
    .opcode (opcode),
    .depth  (depth),
    .run    (run),
    .halted (halted),
    .strb   (strb)
  );

  stack_datapath #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .ADDR_W (ADDR_W),
    .IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW), .DEPTH_W(DEPTH_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .plWrInstr (plWrInstr),
    .plWrData  (plWrData),
    .plAddr    (plAddr),
    .plData    (plData),
    .opcode    (opcode),
    .depth     (depth),
    .tos       (tos),
    .overflow  (overflow),
    .underflow (underflow),
    .halted    (halted)
  );

endmodule

// File: rtl/stack_eval_core_chk.sv
module stack_eval_core_chk #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic [DATA_W-1:0]  tos,
  input logic [DEPTH_W-1:0] depth,
  input logic               overflow,
  input logic               underflow,
  input logic               halted
);

  a_r13_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(DEPTH));

  a_r13_empty_tos_zero: assert property (@(posedge clk) disable iff (rst)
    (depth == '0) |-> (tos == '0));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r8_ovf_when_full: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> (depth == DEPTH_W'(DEPTH)));

  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(depth) && $stable(tos)));

  a_r7_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(depth) && $stable(tos)));

  a_r7_depth_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((depth == $past(depth)) || (depth == $past(depth) + 1'b1) ||
              (depth + 1'b1 == $past(depth))));

endmodule

bind stack_eval_core stack_eval_core_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .tos       (tos),
  .depth     (depth),
  .overflow  (overflow),
  .underflow (underflow),
  .halted    (halted)
);

// File: tb/stack_eval_core_tb.sv
module stack_eval_core_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        plWrInstr = 1'b0;
  logic        plWrData = 1'b0;
  logic [11:0] plAddr = '0;
  logic [31:0] plData = '0;
  logic [31:0] tos;
  logic [3:0]  depth;
  logic        overflow, underflow, halted;

  int nCmp = 0;
  int nBad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_eval_core u_dut (
    .clk(clk), .rst(rst), .run(run),
    .plWrInstr(plWrInstr), .plWrData(plWrData), .plAddr(plAddr), .plData(plData),
    .tos(tos), .depth(depth), .overflow(overflow), .underflow(underflow), .halted(halted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic putI(input int a, input logic [3:0] op, input logic [11:0] fld);
    @(negedge clk); plWrInstr = 1'b1; plAddr = 12'(a); plData = {16'h0, op, fld};
    @(negedge clk); plWrInstr = 1'b0;
  endtask

  task automatic putD(input int a, input logic [31:0] v);
    @(negedge clk); plWrData = 1'b1; plAddr = 12'(a); plData = v;
    @(negedge clk); plWrData = 1'b0;
  endtask

  task automatic step(input int n);
    @(negedge clk); run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); run = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] b, c, d, e, x, y;
    repeat (2) @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 depth", 32'(depth), 0);
    check("R1 tos", tos, 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 underflow", 32'(underflow), 0);
    check("R1 halted", 32'(halted), 0);

    // R7 idle while run low, R2 load from address 0 first, R10 halt
    putD(1, 32'h55);
    putI(0, 4'd1, 12'd1);
    putI(1, 4'd15, 12'd0);
    putI(2, 4'd1, 12'd1);
    repeat (4) @(negedge clk);
    check("R7 idle depth", 32'(depth), 0);
    step(1);
    check("R2 load depth", 32'(depth), 1);
    check("R2 load tos", tos, 32'h55);
    step(1);
    check("R10 halted", 32'(halted), 1);
    step(3);
    check("R10 frozen depth", 32'(depth), 1);
    check("R10 frozen tos", tos, 32'h55);

    // R11 R4 R3 expression sweep with a base entry below
    putD(0, 32'hABC);
    putI(0, 4'd1, 12'd0);
    putI(1, 4'd1, 12'd1);
    putI(2, 4'd1, 12'd2);
    putI(3, 4'd3, 12'd0);
    putI(4, 4'd1, 12'd3);
    putI(5, 4'd1, 12'd4);
    putI(6, 4'd3, 12'd0);
    putI(7, 4'd5, 12'd0);
    putI(8, 4'd2, 12'd9);
    putI(9, 4'd1, 12'd9);
    putI(10, 4'd15, 12'd0);
    for (int i = 0; i < 6; i++) begin
      b = 32'(i) * 32'h9E3779B9 + 32'd1;
      c = (i == 5) ? 32'hFFFF_FFFF : 32'(i * 7 + 2);
      d = 32'(i) * 32'h0101_0101 + 32'd3;
      e = 32'h8000_0000 >> i;
      putD(1, b); putD(2, c); putD(3, d); putD(4, e);
      doReset();
      step(1);
      check("R11 base depth", 32'(depth), 1);
      step(8);
      check("R11 depth restored", 32'(depth), 1);
      check("R11 base tos", tos, 32'hABC);
      step(2);
      check("R3 stored depth", 32'(depth), 2);
      check("R4 R3 result", tos, (b + c) * (d + e));
      check("R9 no underflow", 32'(underflow), 0);
    end

    // R5 SUB sweep
    putI(0, 4'd1, 12'd1);
    putI(1, 4'd1, 12'd2);
    putI(2, 4'd4, 12'd0);
    putI(3, 4'd15, 12'd0);
    for (int i = 0; i < 8; i++) begin
      x = 32'(i * 1000 + 5);
      y = 32'(i * 3333);
      putD(1, x); putD(2, y);
      doReset();
      step(4);
      check("R5 sub depth", 32'(depth), 1);
      check("R5 sub value", tos, x - y);
    end

    // R6 DUP and R8 overflow
    putD(1, 32'h1234_5678);
    putD(2, 32'h0BAD_0BAD);
    putI(0, 4'd1, 12'd1);
    for (int k = 1; k <= 8; k++) putI(k, 4'd6, 12'd0);
    putI(9, 4'd1, 12'd2);
    putI(10, 4'd15, 12'd0);
    doReset();
    for (int k = 1; k <= 9; k++) begin
      step(1);
      check("R6 dup depth", 32'(depth), (k > 8) ? 8 : k);
      check("R6 dup tos", tos, 32'h1234_5678);
      check("R8 overflow flag", 32'(overflow), (k > 8) ? 1 : 0);
    end
    step(1);
    check("R8 load on full depth", 32'(depth), 8);
    check("R8 load on full tos", tos, 32'h1234_5678);
    check("R8 overflow sticky", 32'(overflow), 1);

    // R9 underflow: one-entry ADD and SUB
    putD(1, 32'd7);
    putI(0, 4'd1, 12'd1);
    putI(1, 4'd3, 12'd0);
    putI(2, 4'd4, 12'd0);
    putI(3, 4'd15, 12'd0);
    doReset();
    step(1);
    check("R9 clear before", 32'(underflow), 0);
    step(1);
    check("R9 add one entry", tos, 32'd7);
    check("R9 add depth", 32'(depth), 1);
    check("R9 underflow set", 32'(underflow), 1);
    step(1);
    check("R9 sub one entry", tos, 32'hFFFF_FFF9);
    check("R9 underflow sticky", 32'(underflow), 1);

    // R9 STORE on empty writes zero
    putD(6, 32'h1111);
    putI(0, 4'd2, 12'd6);
    putI(1, 4'd1, 12'd6);
    putI(2, 4'd15, 12'd0);
    doReset();
    step(1);
    check("R9 store empty depth", 32'(depth), 0);
    check("R9 store empty flag", 32'(underflow), 1);
    check("R13 empty tos", tos, 0);
    step(1);
    check("R9 zero stored", tos, 0);
    check("R9 depth after reload", 32'(depth), 1);

    // R12 unassigned opcodes
    putD(1, 32'hAAAA);
    putD(2, 32'hBBBB);
    putI(0, 4'd1, 12'd1);
    putI(1, 4'd0, 12'd1);
    putI(2, 4'd7, 12'd2);
    putI(3, 4'd14, 12'd3);
    putI(4, 4'd1, 12'd2);
    putI(5, 4'd15, 12'd0);
    doReset();
    step(4);
    check("R12 depth", 32'(depth), 1);
    check("R12 tos", tos, 32'hAAAA);
    check("R12 flags", {30'd0, overflow, underflow}, 0);
    step(1);
    check("R12 pc advanced", tos, 32'hBBBB);
    check("R12 depth after", 32'(depth), 2);

    finishRun();
  end

endmodule